// File: doc/BRIEF.md
# Memory-card host transmit buffer with status flags

This block is the outgoing word buffer of a memory-card host controller. Software, or a DMA engine, writes 32-bit words into it over a peripheral register bus. The data-path shifter drains it on the other side. A bus write to any word address inside a 16-word aliased window pushes one word. The drain side always sees the word at the head of the buffer on `tx_word`. Once the shifter has captured that word, it pulses `shift_adv` to move on to the next one.

Two enumerated state machines drive the status outputs. The fill machine has four states:

- `FS_OFF`: the buffer is disabled.
- `FS_EMPTY`: no valid words.
- `FS_PART`: between one and fifteen valid words.
- `FS_FULL`: all sixteen entries valid.

Its transitions are:

- **enable**: `FS_OFF` to `FS_EMPTY`.
- **first push**: `FS_EMPTY` to `FS_PART`.
- **fill**: `FS_PART` to `FS_FULL`, on a push without an advance at fifteen words.
- **drain-out**: `FS_PART` to `FS_EMPTY`, on an advance without a push at one word.
- **first pop**: `FS_FULL` to `FS_PART`.
- **disable**: any state to `FS_OFF`.

The error machine has two states, `UR_CLEAR` and `UR_LATCHED`. Its transitions are:

- **underrun**: `UR_CLEAR` to `UR_LATCHED`, when an advance arrives on an empty buffer while transmit is active.
- **clear**: `UR_LATCHED` to `UR_CLEAR`, on a clear-register write with the underrun bit set.
- **disable**: any state to `UR_CLEAR`.

The half-empty output is meant to be wired to a DMA request line.

Top module: `mc_txbuf`

## Requirements
- R1: `flag_full` is high exactly when all 16 entries hold valid words and the buffer is enabled.
- R2: `flag_empty` is high when the enabled buffer holds no valid word. While the buffer is enabled, `flag_data_avail` is always the inverse of `flag_empty`.
- R3: `flag_half_empty` is high whenever the buffer is enabled and 8 or more of its 16 entries are free.
- R4: A bus write pushes a word when `bus_addr[7:4]` equals the window base bits `4'h4`, whatever `bus_addr[3:0]` holds. A write with any other upper address bits is ignored.
- R5: A bus write while the buffer is full is dropped. The occupancy and the stored words do not change.
- R6: `tx_word` presents the oldest valid word. A `shift_adv` pulse on a non-empty buffer removes that word, and the next word appears after the following clock edge.
- R7: A `shift_adv` pulse on an empty enabled buffer while `tx_active` is high sets `flag_underrun` and does not move the read position. The same pulse with `tx_active` low has no effect.
- R8: `flag_underrun` stays high until a cycle with `clr_wr` high and `clr_data[2]` = 1. A clear write with bit 2 = 0 leaves it set. If a new underrun arrives in the same cycle as a clear, the underrun wins.
- R9: While `fifo_en` is low, all five flags are low, bus writes are ignored, both pointers return to zero and the underrun latch clears. After re-enabling, the buffer reads empty.
- R10: A push and an advance in the same cycle on a buffer that is neither empty nor full leave the occupancy unchanged and keep the word order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | Transmit buffer enable |
| tx_active | input | 1 | Data path is sending |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 8 | Bus word address |
| bus_wdata | input | 32 | Bus write data |
| clr_wr | input | 1 | Clear-register write strobe |
| clr_data | input | 8 | Clear-register write data; bit 2 clears underrun |
| shift_adv | input | 1 | Shifter has captured the head word |
| tx_word | output | 32 | Word at the read pointer |
| flag_full | output | 1 | All entries valid |
| flag_empty | output | 1 | No entry valid |
| flag_half_empty | output | 1 | At least half the entries free; DMA request |
| flag_data_avail | output | 1 | Inverse of empty while enabled |
| flag_underrun | output | 1 | Sticky underrun error |

## Verification
The bench builds the block with its default parameters: 16 entries of 32 bits, an 8-bit word address with window base 0x40, and clear bit 2. Those values put every boundary within a few dozen cycles:

- the 8/9-word edge of the half-empty request;
- the full state and the dropped write beyond it;
- drain to empty, followed by an underrun advance;
- disable, and the pointer reset it causes.

Pushes walk all 16 aliased addresses, and a write just outside the window at 0x50 checks that the upper address bits are decoded.

// File: rtl/mc_txbuf_pkg.sv
package mc_txbuf_pkg;

    typedef enum logic [1:0] {
        FS_OFF   = 2'd0,
        FS_EMPTY = 2'd1,
        FS_PART  = 2'd2,
        FS_FULL  = 2'd3
    } fill_state_t;

    typedef enum logic {
        UR_CLEAR   = 1'b0,
        UR_LATCHED = 1'b1
    } ur_state_t;

endpackage

// File: rtl/mc_txbuf_store.sv
module mc_txbuf_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] entry [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                entry[g] <= wr_data;
            end
        end
    end

    assign rd_data = entry[rd_idx];

endmodule

// File: rtl/mc_txbuf_ptrs.sv
module mc_txbuf_ptrs #(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int PTR_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic             pop,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] rd_idx,
    output logic [PTR_W-1:0] occ
);

    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
        end else if (push) begin
            wr_ptr <= wr_ptr + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rd_ptr <= '0;
        end else if (pop) begin
            rd_ptr <= rd_ptr + PTR_W'(1);
        end
    end

    assign wr_idx = wr_ptr[IDX_W-1:0];
    assign rd_idx = rd_ptr[IDX_W-1:0];
    assign occ    = wr_ptr - rd_ptr;

endmodule

// File: rtl/mc_txbuf_ctrl.sv
module mc_txbuf_ctrl
    import mc_txbuf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PTR_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             push_req,
    input  logic             adv,
    input  logic             tx_active,
    input  logic             clr_hit,
    input  logic [PTR_W-1:0] occ,
    output logic             push_ok,
    output logic             pop_ok,
    output logic             flag_full,
    output logic             flag_empty,
    output logic             flag_half_empty,
    output logic             flag_data_avail,
    output logic             flag_underrun
);

    localparam logic [PTR_W-1:0] LAST_CNT = PTR_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0] HALF_CNT = PTR_W'(DEPTH / 2);
    localparam logic [PTR_W-1:0] ONE_CNT  = PTR_W'(1);

    fill_state_t fs_q, fs_d, fs_view;
    ur_state_t   ur_q, ur_d;
    logic        ur_set;

    // The disabled state behaves as empty once enable returns; the pointers are already zero.
    always_comb begin
        fs_view = (fs_q == FS_OFF) ? FS_EMPTY : fs_q;
    end

    always_comb begin
        push_ok = fifo_en && push_req && (fs_view != FS_FULL);
        pop_ok  = fifo_en && adv && (fs_view != FS_EMPTY);
        ur_set  = fifo_en && adv && tx_active && (fs_view == FS_EMPTY);
    end

    always_comb begin
        fs_d = fs_view;
        if (!fifo_en) begin
            fs_d = FS_OFF;
        end else begin
            unique case (fs_view)
                FS_OFF: begin
                    fs_d = FS_EMPTY;
                end
                FS_EMPTY: begin
                    if (push_ok) fs_d = FS_PART;
                end
                FS_PART: begin
                    if (push_ok && !pop_ok && (occ == LAST_CNT)) begin
                        fs_d = FS_FULL;
                    end else if (pop_ok && !push_ok && (occ == ONE_CNT)) begin
                        fs_d = FS_EMPTY;
                    end
                end
                FS_FULL: begin
                    if (pop_ok) fs_d = FS_PART;
                end
            endcase
        end
    end

    always_comb begin
        ur_d = ur_q;
        if (!fifo_en) begin
            ur_d = UR_CLEAR;
        end else begin
            unique case (ur_q)
                UR_CLEAR: begin
                    if (ur_set) ur_d = UR_LATCHED;
                end
                UR_LATCHED: begin
                    if (clr_hit && !ur_set) ur_d = UR_CLEAR;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q <= FS_OFF;
            ur_q <= UR_CLEAR;
        end else begin
            fs_q <= fs_d;
            ur_q <= ur_d;
        end
    end

    always_comb begin
        flag_full       = 1'b0;
        flag_empty      = 1'b0;
        flag_half_empty = 1'b0;
        flag_data_avail = 1'b0;
        if (fifo_en) begin
            unique case (fs_view)
                FS_OFF, FS_EMPTY: begin
                    flag_empty      = 1'b1;
                    flag_half_empty = 1'b1;
                end
                FS_PART: begin
                    flag_data_avail = 1'b1;
                    flag_half_empty = (occ <= HALF_CNT);
                end
                FS_FULL: begin
                    flag_full       = 1'b1;
                    flag_data_avail = 1'b1;
                end
            endcase
        end
        flag_underrun = fifo_en && (ur_q == UR_LATCHED);
    end

endmodule

// File: rtl/mc_txbuf.sv
module mc_txbuf #(
    parameter int              DEPTH    = 16,
    parameter int              DATA_W   = 32,
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] WIN_BASE = 8'h40,
    parameter int              CLR_W    = 8,
    parameter int              CLR_BIT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              tx_active,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              clr_wr,
    input  logic [CLR_W-1:0]  clr_data,
    input  logic              shift_adv,
    output logic [DATA_W-1:0] tx_word,
    output logic              flag_full,
    output logic              flag_empty,
    output logic              flag_half_empty,
    output logic              flag_data_avail,
    output logic              flag_underrun
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int PTR_W = IDX_W + 1;

    logic             win_hit;
    logic             push_req;
    logic             clr_hit;
    logic             push_ok;
    logic             pop_ok;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [PTR_W-1:0] occ;
    logic             unused_addr_lo;
    logic             unused_clr_bits;

    // The low address bits select an alias inside the window and carry no meaning.
    assign win_hit  = (bus_addr[ADDR_W-1:IDX_W] == WIN_BASE[ADDR_W-1:IDX_W]);
    assign push_req = bus_wr && win_hit;
    assign clr_hit  = clr_wr && clr_data[CLR_BIT];

    assign unused_addr_lo  = ^bus_addr[IDX_W-1:0];
    assign unused_clr_bits = ^clr_data;

    mc_txbuf_ctrl #(
        .DEPTH (DEPTH),
        .PTR_W (PTR_W)
    ) i_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .fifo_en         (fifo_en),
        .push_req        (push_req),
        .adv             (shift_adv),
        .tx_active       (tx_active),
        .clr_hit         (clr_hit),
        .occ             (occ),
        .push_ok         (push_ok),
        .pop_ok          (pop_ok),
        .flag_full       (flag_full),
        .flag_empty      (flag_empty),
        .flag_half_empty (flag_half_empty),
        .flag_data_avail (flag_data_avail),
        .flag_underrun   (flag_underrun)
    );

    mc_txbuf_ptrs #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W),
        .PTR_W (PTR_W)
    ) i_ptrs (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (!fifo_en),
        .push   (push_ok),
        .pop    (pop_ok),
        .wr_idx (wr_idx),
        .rd_idx (rd_idx),
        .occ    (occ)
    );

    mc_txbuf_store #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) i_store (
        .clk     (clk),
        .wr_en   (push_ok),
        .wr_idx  (wr_idx),
        .wr_data (bus_wdata),
        .rd_idx  (rd_idx),
        .rd_data (tx_word)
    );

endmodule

// File: rtl/mc_txbuf_chk.sv
module mc_txbuf_chk #(
    parameter int DEPTH = 16,
    parameter int PTR_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en,
    input logic             tx_active,
    input logic             shift_adv,
    input logic             clr_hit,
    input logic [PTR_W-1:0] occ,
    input logic             flag_full,
    input logic             flag_empty,
    input logic             flag_half_empty,
    input logic             flag_data_avail,
    input logic             flag_underrun
);

    localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] HALF_CNT = PTR_W'(DEPTH / 2);

    p_full_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_en |-> (flag_full == (occ == FULL_CNT)));

    p_avail_inverse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_en |-> (flag_data_avail != flag_empty));

    p_half_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_en |-> (flag_half_empty == (occ <= HALF_CNT)));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && flag_full && !shift_adv) |=> (occ == FULL_CNT));

    p_underrun_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && flag_empty && shift_adv && tx_active) |=> (flag_underrun || !fifo_en));

    p_underrun_no_move_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && flag_empty && shift_adv) |=> (occ <= PTR_W'(1)));

    p_underrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && flag_underrun && !clr_hit) |=> (flag_underrun || !fifo_en));

    p_off_flags_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> !(flag_full || flag_empty || flag_half_empty || flag_data_avail || flag_underrun));

    p_off_ptr_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |=> (occ == '0));

endmodule

bind mc_txbuf mc_txbuf_chk #(
    .DEPTH (DEPTH),
    .PTR_W (PTR_W)
) i_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .fifo_en         (fifo_en),
    .tx_active       (tx_active),
    .shift_adv       (shift_adv),
    .clr_hit         (clr_hit),
    .occ             (occ),
    .flag_full       (flag_full),
    .flag_empty      (flag_empty),
    .flag_half_empty (flag_half_empty),
    .flag_data_avail (flag_data_avail),
    .flag_underrun   (flag_underrun)
);

// File: tb/test_mc_txbuf.sv
`timescale 1ns/1ps
module test_mc_txbuf;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_en = 1'b0;
    logic        tx_active = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic        clr_wr = 1'b0;
    logic [7:0]  clr_data = 8'h00;
    logic        shift_adv = 1'b0;
    logic [31:0] tx_word;
    logic        flag_full, flag_empty, flag_half_empty, flag_data_avail, flag_underrun;

    int n_tests = 0;
    int n_fail  = 0;
    bit checking = 0;
    bit done = 0;
    string phase = "reset";

    logic [31:0] model_q[$];
    bit          model_ur = 0;

    always #4 clk = ~clk;

    mc_txbuf i_mc_txbuf (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .tx_active(tx_active),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .clr_wr(clr_wr), .clr_data(clr_data), .shift_adv(shift_adv),
        .tx_word(tx_word), .flag_full(flag_full), .flag_empty(flag_empty),
        .flag_half_empty(flag_half_empty), .flag_data_avail(flag_data_avail),
        .flag_underrun(flag_underrun)
    );

    // Behavioural reference, advanced on every rising edge.
    always @(posedge clk) begin
        int  sz;
        bit  hit, do_push, do_pop, ur_set;
        sz = model_q.size();
        if (!rst_n || !fifo_en) begin
            model_q.delete();
            model_ur = 0;
        end else begin
            hit     = ((int'(bus_addr) >> 4) == (8'h40 >> 4));
            do_push = bus_wr && hit && (sz < DEPTH);
            do_pop  = shift_adv && (sz > 0);
            ur_set  = shift_adv && (sz == 0) && tx_active;
            if (do_pop)  void'(model_q.pop_front());
            if (do_push) model_q.push_back(bus_wdata);
            if (ur_set) model_ur = 1;
            else if (clr_wr && clr_data[2]) model_ur = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s [%s] %s act=%0h exp=%0h", tag, phase, what, act, exp);
        end
    endtask

    task automatic compare_all();
        int sz;
        bit e_full, e_empty, e_half, e_avail, e_ur;
        sz = model_q.size();
        e_full  = fifo_en && (sz == DEPTH);
        e_empty = fifo_en && (sz == 0);
        e_avail = fifo_en && (sz > 0);
        e_half  = fifo_en && ((DEPTH - sz) >= 8);
        e_ur    = fifo_en && model_ur;
        if (!fifo_en) begin
            chk(!(flag_full || flag_empty || flag_half_empty || flag_data_avail || flag_underrun),
                "R9", "flags while disabled",
                {27'd0, flag_full, flag_empty, flag_half_empty, flag_data_avail, flag_underrun}, 32'd0);
        end else begin
            chk(flag_full == e_full, "R1", "flag_full", 32'(flag_full), 32'(e_full));
            chk(flag_empty == e_empty, "R2", "flag_empty", 32'(flag_empty), 32'(e_empty));
            chk(flag_data_avail == e_avail, "R2", "flag_data_avail", 32'(flag_data_avail), 32'(e_avail));
            chk(flag_half_empty == e_half, "R3", "flag_half_empty", 32'(flag_half_empty), 32'(e_half));
            chk(flag_underrun == e_ur, "R7/R8", "flag_underrun", 32'(flag_underrun), 32'(e_ur));
            if (sz > 0) chk(tx_word === model_q[0], "R6", "tx_word", tx_word, model_q[0]);
        end
    endtask

    always @(negedge clk) begin
        if (checking && rst_n) compare_all();
    end

    task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d,
                       input logic ad, input logic ta, input logic cw, input logic [7:0] cd);
        bus_wr = w; bus_addr = a; bus_wdata = d; shift_adv = ad;
        tx_active = ta; clr_wr = cw; clr_data = cd;
        @(negedge clk); #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 8'h00, 32'h0, 0, 0, 0, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        rst_n = 1'b1;
        checking = 1;
        phase = "R9 disabled after reset";
        cyc(1, 8'h40, 32'h1111_0000, 0, 0, 0, 8'h00);
        idle(2);

        fifo_en = 1'b1;
        phase = "R2 enabled empty";
        idle(2);

        phase = "R4 R3 fill through aliased addresses";
        for (int i = 0; i < 16; i++) cyc(1, 8'h40 + 8'(i), 32'hA000_0000 + 32'(i), 0, 0, 0, 8'h00);

        phase = "R5 R4 writes while full and outside window";
        cyc(1, 8'h43, 32'hDEAD_0001, 0, 0, 0, 8'h00);
        cyc(1, 8'h4F, 32'hDEAD_0002, 0, 0, 0, 8'h00);
        cyc(1, 8'h50, 32'hDEAD_0003, 0, 0, 0, 8'h00);
        idle(1);

        phase = "R6 drain in order";
        for (int i = 0; i < 16; i++) cyc(0, 8'h00, 32'h0, 1, 1, 0, 8'h00);

        phase = "R7 advance while empty, transmit idle";
        cyc(0, 8'h00, 32'h0, 1, 0, 0, 8'h00);
        idle(1);

        phase = "R4 outside window at empty";
        cyc(1, 8'h3F, 32'hBAD0_0001, 0, 0, 0, 8'h00);
        cyc(1, 8'h50, 32'hBAD0_0002, 0, 0, 0, 8'h00);
        idle(1);

        phase = "R7 underrun";
        cyc(0, 8'h00, 32'h0, 1, 1, 0, 8'h00);
        idle(1);
        cyc(1, 8'h4A, 32'hC0DE_0001, 0, 0, 0, 8'h00);
        idle(1);

        phase = "R8 clear without bit";
        cyc(0, 8'h00, 32'h0, 0, 0, 1, 8'hFB);
        idle(1);
        phase = "R8 clear collides with new underrun";
        cyc(0, 8'h00, 32'h0, 1, 1, 0, 8'h00);
        cyc(0, 8'h00, 32'h0, 1, 1, 1, 8'h04);
        idle(1);
        phase = "R8 clear with bit 2";
        cyc(0, 8'h00, 32'h0, 0, 0, 1, 8'h04);
        idle(1);

        phase = "R10 push and advance together";
        cyc(1, 8'h41, 32'hB000_0001, 0, 0, 0, 8'h00);
        cyc(1, 8'h42, 32'hB000_0002, 1, 1, 0, 8'h00);
        for (int i = 0; i < 4; i++) cyc(1, 8'h44 + 8'(i), 32'hB100_0000 + 32'(i), 0, 0, 0, 8'h00);
        for (int i = 0; i < 3; i++) cyc(1, 8'h48 + 8'(i), 32'hB200_0000 + 32'(i), 1, 1, 0, 8'h00);
        phase = "R3 half boundary 8 and 9";
        for (int i = 0; i < 4; i++) cyc(1, 8'h4C, 32'hB300_0000 + 32'(i), 0, 0, 0, 8'h00);
        phase = "R1 R10 push and advance at full";
        for (int i = 0; i < 7; i++) cyc(1, 8'h4D, 32'hB400_0000 + 32'(i), 0, 0, 0, 8'h00);
        cyc(1, 8'h4E, 32'hB500_0000, 1, 1, 0, 8'h00);
        idle(1);

        phase = "R9 disable with data and underrun";
        for (int i = 0; i < 16; i++) cyc(0, 8'h00, 32'h0, 1, 1, 0, 8'h00);
        cyc(0, 8'h00, 32'h0, 1, 1, 0, 8'h00);
        fifo_en = 1'b0;
        cyc(1, 8'h40, 32'hEEEE_0000, 0, 0, 0, 8'h00);
        idle(2);
        fifo_en = 1'b1;
        phase = "R9 re-enabled empty";
        idle(2);
        cyc(1, 8'h45, 32'hF000_0001, 0, 0, 0, 8'h00);
        idle(2);

        checking = 0;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule